// File: doc/BRIEF.md
# Strobe-Driven Packet FIFO Receiver

This block receives words from an external processor that writes over an asynchronous strobe port. The port has an active-low chip select, an active-low write strobe, an active-low packet-end strobe, a FIFO address and a data bus. All of these inputs are brought into the block's clock domain by synchronizer stages. A word is stored when the write strobe is released. The data and address used are the values present just before the release.

Each addressed FIFO holds entries tagged with an end-of-packet bit and a zero-length bit. Holding packet-end low through a write makes that word the last word of its packet. A packet-end pulse with no write puts a zero-length packet marker into the FIFO. Only committed packets are offered on the read side. Words of an unfinished packet stay hidden from the reader. The reader picks one FIFO and takes entries with a valid/ready handshake. Each entry carries a last marker and a zero-length marker.

For flow control the block drives empty, full and partial flags. These describe either one configured FIFO or the FIFO currently on the address lines. The partial threshold is a word count that can be changed at run time. A write or marker aimed at a full FIFO is dropped, and this sets a sticky overflow bit.

Top module: `strobe_fifo_rx`

## Requirements
- R1: After reset, flag_empty_o=1, flag_full_o=0, overflow_o=0 and m_valid_o=0; flag_partial_o=0 whenever partial_thresh_i is nonzero.
- R2: With cs_ni low, a low-to-high transition of wr_ni stores the data_i value held before the transition into the FIFO selected by addr_i. Each FIFO returns its words in write order.
- R3: While cs_ni is high, pulses on wr_ni and pktend_ni change no FIFO contents and no flag.
- R4: A word whose write strobe is released while pktend_ni is still low is marked last (m_last_o=1, m_zlp_o=0) and commits its packet.
- R5: A pktend_ni low pulse with cs_ni low and no write strobe during it enqueues one marker, read as m_zlp_o=1, m_last_o=1, m_data_o=0.
- R6: m_valid_o is 1 only when the FIFO selected by rd_sel_i holds at least one entry of a committed packet. Words after the last commit stay invisible.
- R7: With flag_fixed_i=1 the flags describe the FIFO at flag_addr_i; with flag_fixed_i=0 they describe the FIFO at addr_i. For that FIFO's occupancy n: empty is n==0, full is n==DEPTH, partial is n>=partial_thresh_i.
- R8: The flags reflect a write or marker no later than 6 clock cycles after the releasing strobe edge at the pins.
- R9: A write or marker to a FIFO holding DEPTH entries is dropped, and overflow_o goes to 1 and stays 1 until reset.
- R10: An entry is removed from the FIFO at rd_sel_i on a clock edge where m_valid_o and m_ready_i are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low, asynchronous |
| wr_ni | input | 1 | Write strobe, active low, asynchronous |
| pktend_ni | input | 1 | Packet-end strobe, active low, asynchronous |
| addr_i | input | ADDR_W | FIFO address, asynchronous |
| data_i | input | DATA_W | Write data, asynchronous |
| flag_fixed_i | input | 1 | 1: flags track flag_addr_i, 0: flags track addr_i |
| flag_addr_i | input | ADDR_W | Configured FIFO for the flags |
| partial_thresh_i | input | PTR_W | Occupancy at which the partial flag is raised |
| flag_empty_o | output | 1 | Tracked FIFO is empty |
| flag_full_o | output | 1 | Tracked FIFO is full |
| flag_partial_o | output | 1 | Tracked FIFO occupancy at or above threshold |
| overflow_o | output | 1 | Sticky: a write or marker was dropped |
| rd_sel_i | input | ADDR_W | FIFO chosen for the read stream |
| m_valid_o | output | 1 | Committed entry available |
| m_ready_i | input | 1 | Reader accepts the entry |
| m_data_o | output | DATA_W | Entry data |
| m_last_o | output | 1 | Entry ends a packet |
| m_zlp_o | output | 1 | Entry is a zero-length packet marker |

## Verification
The bench builds the block with DATA_W=8, NUM_FIFOS=4 and DEPTH=4. With a depth this small, random traffic reaches full FIFOs, dropped writes and the overflow bit often. Every partial threshold from 1 to DEPTH is reachable, and traffic spreads over all four FIFOs. Packets often stay open across other FIFOs' traffic, and open packets can fill a FIFO while no entry is visible to the reader.

// File: rtl/strobe_fifo_rx_pkg.sv
package strobe_fifo_rx_pkg;
  typedef struct packed {
    logic wr;
    logic zlp;
    logic last;
  } strobe_evt_t;
endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sfr_decode.sv
module sfr_decode
  import strobe_fifo_rx_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              wr_n_i,
  input  logic              pe_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output strobe_evt_t       evt_o,
  output logic [ADDR_W-1:0] evt_addr_o,
  output logic [DATA_W-1:0] evt_data_o
);
  logic              cs_d, wr_d, pe_d, pe_used_q;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] data_d;
  logic              wr_rise, pe_rise, wr_hit, zlp_hit;

  // pre-edge values are used: data and packet-end as seen before release
  assign wr_rise = !wr_d && wr_n_i;
  assign pe_rise = !pe_d && pe_n_i;
  assign wr_hit  = wr_rise && !cs_d;
  assign zlp_hit = pe_rise && !cs_d && !pe_used_q && !wr_hit && wr_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_d       <= 1'b1;
      wr_d       <= 1'b1;
      pe_d       <= 1'b1;
      addr_d     <= '0;
      data_d     <= '0;
      pe_used_q  <= 1'b0;
      evt_o      <= '0;
      evt_addr_o <= '0;
      evt_data_o <= '0;
    end else begin
      cs_d   <= cs_n_i;
      wr_d   <= wr_n_i;
      pe_d   <= pe_n_i;
      addr_d <= addr_i;
      data_d <= data_i;
      if (pe_rise)              pe_used_q <= 1'b0;
      else if (wr_hit && !pe_d) pe_used_q <= 1'b1;
      evt_o.wr   <= wr_hit;
      evt_o.zlp  <= zlp_hit;
      evt_o.last <= wr_hit && !pe_d;
      evt_addr_o <= addr_d;
      evt_data_o <= wr_hit ? data_d : '0;
    end
  end

  AST_EVT_ONE_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o.zlp |-> !evt_o.wr && !evt_o.last) else $error("zlp with write"); // R5
endmodule

// File: rtl/sfr_fifo_bank.sv
module sfr_fifo_bank #(
  parameter int NUM_FIFOS = 4,
  parameter int DEPTH     = 8,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 2,
  parameter int PTR_W     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              zlp_i,
  input  logic              last_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [ADDR_W-1:0] sel_i,
  input  logic              pop_i,
  output logic [PTR_W-1:0]  occ_o [NUM_FIFOS],
  output logic              drop_o,
  output logic              avail_o,
  output logic [DATA_W-1:0] data_o,
  output logic              last_o,
  output logic              zlp_o
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int EW    = DATA_W + 2;

  logic [NUM_FIFOS-1:0] full_v, avail_v;
  logic [EW-1:0]        ent_v [NUM_FIFOS];
  logic                 any_evt;

  assign any_evt = wr_i || zlp_i;

  for (genvar g = 0; g < NUM_FIFOS; g++) begin : g_fifo
    logic [PTR_W-1:0] wr_q, rd_q, cm_q, cm_occ;
    logic [EW-1:0]    mem_q [DEPTH];
    logic             push, pop;

    assign occ_o[g]   = wr_q - rd_q;
    assign cm_occ     = cm_q - rd_q;
    assign full_v[g]  = occ_o[g] == PTR_W'(DEPTH);
    assign avail_v[g] = cm_q != rd_q;
    assign push = any_evt && (addr_i == ADDR_W'(g)) && !full_v[g];
    assign pop  = pop_i && (sel_i == ADDR_W'(g)) && avail_v[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wr_q <= '0;
        rd_q <= '0;
        cm_q <= '0;
      end else begin
        if (push) wr_q <= wr_q + 1'b1;
        if (push && (last_i || zlp_i)) cm_q <= wr_q + 1'b1;
        if (pop) rd_q <= rd_q + 1'b1;
      end
    end

    always_ff @(posedge clk_i) begin
      if (push) mem_q[wr_q[IDX_W-1:0]] <= {zlp_i, last_i | zlp_i, zlp_i ? '0 : data_i};
    end

    assign ent_v[g] = mem_q[rd_q[IDX_W-1:0]];

    AST_OCC_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      occ_o[g] <= PTR_W'(DEPTH)) else $error("occupancy past depth"); // R9
    AST_COMMIT_INSIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cm_occ <= occ_o[g]) else $error("commit point beyond write point"); // R6
  end

  always_comb begin
    drop_o  = 1'b0;
    avail_o = 1'b0;
    data_o  = '0;
    last_o  = 1'b0;
    zlp_o   = 1'b0;
    for (int g = 0; g < NUM_FIFOS; g++) begin
      if (any_evt && addr_i == ADDR_W'(g) && full_v[g]) drop_o = 1'b1;
      if (sel_i == ADDR_W'(g)) begin
        avail_o = avail_v[g];
        {zlp_o, last_o, data_o} = ent_v[g];
      end
    end
  end
endmodule

// File: rtl/strobe_fifo_rx.sv
module strobe_fifo_rx
  import strobe_fifo_rx_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int NUM_FIFOS = 4,
  parameter int DEPTH     = 8,
  parameter int ADDR_W    = (NUM_FIFOS > 1) ? $clog2(NUM_FIFOS) : 1,
  parameter int PTR_W     = $clog2(DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              wr_ni,
  input  logic              pktend_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              flag_fixed_i,
  input  logic [ADDR_W-1:0] flag_addr_i,
  input  logic [PTR_W-1:0]  partial_thresh_i,
  output logic              flag_empty_o,
  output logic              flag_full_o,
  output logic              flag_partial_o,
  output logic              overflow_o,
  input  logic [ADDR_W-1:0] rd_sel_i,
  output logic              m_valid_o,
  input  logic              m_ready_i,
  output logic [DATA_W-1:0] m_data_o,
  output logic              m_last_o,
  output logic              m_zlp_o
);
  localparam int SW = 3 + ADDR_W + DATA_W;
  localparam logic [SW-1:0] SYNC_RST = {3'b111, {(ADDR_W + DATA_W){1'b0}}};

  logic              cs_s, wr_s, pe_s;
  logic [ADDR_W-1:0] addr_s, evt_addr, flag_idx;
  logic [DATA_W-1:0] data_s, evt_data;
  strobe_evt_t       evt;
  logic [PTR_W-1:0]  occ [NUM_FIFOS];
  logic [PTR_W-1:0]  flag_occ;
  logic              drop, ovf_q;

  sfr_sync #(.W(SW), .STAGES(2), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, wr_ni, pktend_ni, addr_i, data_i}),
    .q_o   ({cs_s, wr_s, pe_s, addr_s, data_s})
  );

  sfr_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_n_i    (cs_s),
    .wr_n_i    (wr_s),
    .pe_n_i    (pe_s),
    .addr_i    (addr_s),
    .data_i    (data_s),
    .evt_o     (evt),
    .evt_addr_o(evt_addr),
    .evt_data_o(evt_data)
  );

  sfr_fifo_bank #(
    .NUM_FIFOS(NUM_FIFOS), .DEPTH(DEPTH), .DATA_W(DATA_W),
    .ADDR_W(ADDR_W), .PTR_W(PTR_W)
  ) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (evt.wr),
    .zlp_i  (evt.zlp),
    .last_i (evt.last),
    .addr_i (evt_addr),
    .data_i (evt_data),
    .sel_i  (rd_sel_i),
    .pop_i  (m_ready_i),
    .occ_o  (occ),
    .drop_o (drop),
    .avail_o(m_valid_o),
    .data_o (m_data_o),
    .last_o (m_last_o),
    .zlp_o  (m_zlp_o)
  );

  assign flag_idx = flag_fixed_i ? flag_addr_i : addr_s;

  always_comb begin
    flag_occ = '0;
    for (int g = 0; g < NUM_FIFOS; g++)
      if (flag_idx == ADDR_W'(g)) flag_occ = occ[g];
  end

  assign flag_empty_o   = flag_occ == '0;
  assign flag_full_o    = flag_occ == PTR_W'(DEPTH);
  assign flag_partial_o = flag_occ >= partial_thresh_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= 1'b0;
    else if (drop) ovf_q <= 1'b1;
  end
  assign overflow_o = ovf_q;

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o) else $error("overflow cleared"); // R9
  AST_ZLP_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_valid_o && m_zlp_o) |-> (m_last_o && m_data_o == '0)) else $error("bad zlp entry"); // R5
endmodule

// File: tb/strobe_fifo_rx_tb_top.sv
module strobe_fifo_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int NF = 4;
  localparam int DP = 4;
  localparam int AW = 2;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic cs_n, wr_n, pe_n, fixed, ready, f_empty, f_full, f_part, ovf, m_valid, m_last, m_zlp;
  logic [AW-1:0] addr, faddr, rd_sel;
  logic [DW-1:0] data, m_data;
  logic [PW-1:0] thr;

  int checks = 0;
  int errors = 0;
  logic [DW+1:0] q [NF][$];
  int cm [NF];
  bit exp_ovf = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strobe_fifo_rx #(.DATA_W(DW), .NUM_FIFOS(NF), .DEPTH(DP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .wr_ni(wr_n), .pktend_ni(pe_n),
    .addr_i(addr), .data_i(data), .flag_fixed_i(fixed), .flag_addr_i(faddr),
    .partial_thresh_i(thr), .flag_empty_o(f_empty), .flag_full_o(f_full),
    .flag_partial_o(f_part), .overflow_o(ovf), .rd_sel_i(rd_sel),
    .m_valid_o(m_valid), .m_ready_i(ready), .m_data_o(m_data),
    .m_last_o(m_last), .m_zlp_o(m_zlp)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int tracked();
    return fixed ? int'(faddr) : int'(addr);
  endfunction

  task automatic check_flags(input string req);
    int n = q[tracked()].size();
    chk(req, f_empty, n == 0, "empty flag");
    chk(req, f_full, n == DP, "full flag");
    chk(req, f_part, n >= int'(thr), "partial flag");
    chk("R9", ovf, exp_ovf, "overflow");
  endtask

  task automatic model_push(input int a, input logic [DW+1:0] e, input bit commit);
    if (q[a].size() == DP) exp_ovf = 1;
    else begin
      q[a].push_back(e);
      if (commit) cm[a] = q[a].size();
    end
  endtask

  task automatic do_write(input int a, input logic [DW-1:0] d, input bit last, input bit ign,
                          input string req);
    @(negedge clk);
    addr = AW'(a); data = d; cs_n = ign;
    repeat (2) @(negedge clk);
    wr_n = 1'b0; if (last) pe_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    repeat (3) @(negedge clk);
    data = DW'($urandom); pe_n = 1'b1;
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    if (!ign) model_push(a, {1'b0, last, d}, last);
    repeat (1) @(negedge clk);
    check_flags(req); // taken 6 cycles after the write strobe release: R8
  endtask

  task automatic do_zlp(input int a, input bit ign, input string req);
    @(negedge clk);
    addr = AW'(a); cs_n = ign;
    repeat (2) @(negedge clk);
    pe_n = 1'b0;
    repeat (3) @(negedge clk);
    pe_n = 1'b1;
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    if (!ign) model_push(a, {2'b11, {DW{1'b0}}}, 1'b1);
    repeat (4) @(negedge clk);
    check_flags(req);
  endtask

  task automatic do_pop(input int f);
    logic [DW+1:0] e;
    @(negedge clk);
    rd_sel = AW'(f);
    @(negedge clk);
    chk("R6", m_valid, cm[f] > 0, "m_valid");
    if (cm[f] > 0) begin
      e = q[f].pop_front();
      cm[f]--;
      chk("R2", m_data, e[DW-1:0], "data");
      chk("R4", m_last, e[DW], "last");
      chk("R5", m_zlp, e[DW+1], "zlp");
      ready = 1'b1;
      @(negedge clk);
      ready = 1'b0;
      check_flags("R10");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; cs_n = 1'b1; wr_n = 1'b1; pe_n = 1'b1; addr = '0; data = '0;
    fixed = 1'b1; faddr = '0; thr = 3'd2; rd_sel = '0; ready = 1'b0;
    for (int i = 0; i < NF; i++) cm[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", f_empty, 1, "empty"); chk("R1", f_full, 0, "full");
    chk("R1", f_part, 0, "partial"); chk("R1", ovf, 0, "overflow");
    chk("R1", m_valid, 0, "m_valid");

    // open packet on FIFO 0 stays invisible
    do_write(0, 8'h11, 0, 0, "R8");
    do_write(0, 8'h22, 0, 0, "R7");
    do_pop(0);
    do_write(0, 8'h33, 1, 0, "R4");
    for (int i = 0; i < 3; i++) do_pop(0);
    // zero-length marker on FIFO 1
    do_zlp(1, 0, "R5");
    do_pop(1);
    // ignored strobes with chip select high
    do_write(2, 8'h5a, 1, 1, "R3");
    do_zlp(2, 1, "R3");
    fixed = 1'b0;
    do_pop(2);
    // fill FIFO 3, then overflow
    thr = 3'd4;
    for (int i = 0; i < DP; i++) do_write(3, DW'(8'h40 + i), i == DP - 1, 0, "R7");
    do_write(3, 8'hee, 1, 0, "R9");
    do_zlp(3, 0, "R9");
    for (int i = 0; i < DP; i++) do_pop(3);

    for (int it = 0; it < 200; it++) begin
      int r = $urandom % 100;
      int a = $urandom % NF;
      fixed = 1'($urandom);
      faddr = AW'($urandom);
      thr = PW'(1 + $urandom % DP);
      if (r < 6) do_write(a, DW'($urandom), 1'($urandom), 1, "R3");
      else if (r < 10) do_zlp(a, 1, "R3");
      else if (r < 18) do_zlp(a, 0, "R5");
      else if (r < 45) do_pop(a);
      else do_write(a, DW'($urandom), ($urandom % 4) == 0, 0, "R2");
    end
    for (int f = 0; f < NF; f++) begin
      int n = cm[f];
      for (int i = 0; i <= n; i++) do_pop(f);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule